// File: doc/BRIEF.md
# Two-Stage Bark/Bite Watchdog Timer

This block is a register-programmed watchdog with two timers that run one after the other. The first timer measures a warning window in whole seconds. When it expires, the block raises a level interrupt ("bark") toward the host processor. The second timer then starts. If software has not serviced the watchdog by the time the second timer runs out, the block emits a one-cycle reset request ("bite"). The request carries a reset-type code that software has chosen.

Software writes the two durations and the reset type, and arms or disarms the block through a control bit. It keeps the system alive by writing a service ("pet") bit, which sends the sequence back to the start of the first timer. A one-second tick comes from the system clock through a prescaler whose ratio is a parameter. A plain synchronous register port gives access to the block. Reads are combinational from the address. A status register shows the bark condition as it happens.

Top module: `bark_bite_wdt`

## Requirements
- R1: After reset: stage-one duration is 32, stage-two duration is 0, reset type is 0x07, the enable bit is 0, and both `bark_irq` and `rst_req` are low.
- R2: Register layout. Stage-one duration is at 0x54 and stage-two duration is at 0x55, each held in bits 6:0. Reset type is at 0x56, bits 2:0. Enable is at 0x57, bit 7. Pet is at 0x58, write only, and reads 0. Status is at 0x10, bit 6. Any other address reads 0.
- R3: The reset type accepts only the codes 0x01 (warm), 0x04 (shutdown) and 0x07 (hard). A write of any other value is ignored and leaves the stored code unchanged.
- R4: Bark timing. While the block is enabled, `bark_irq` rises exactly S1 ticks after the write that started the sequence, where S1 is the stage-one duration and 0 counts as 1. Status bit 6 then reads 1. Bark stays high until a pet or a write to the enable register.
- R5: Bite timing. `rst_req` is a single-cycle pulse. It fires S2 ticks after bark, where S2 is the stage-two duration and 0 counts as 1, so a zero stage two bites on the very next tick. During the pulse, `rst_type` carries the stored reset type.
- R6: After a bite, the timers hold. Neither bark nor bite happens again until a pet or a write to the enable register.
- R7: Writing 0x58 with bit 0 set restarts the sequence from the start of stage one and clears bark. A pet during stage two prevents the bite. Writing 0x58 with bit 0 clear has no effect.
- R8: Any write to 0x57 restarts the sequence. With bit 7 clear, the block stops counting, clears bark and never bites. With bit 7 set, counting begins anew from stage one.
- R9: One tick equals `TICK_DIV` clock cycles, counted from the edge of the restarting write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| bark_irq | output | 1 | Bark interrupt level; the host takes its rising edge |
| rst_req | output | 1 | One-cycle reset request |
| rst_type | output | 3 | Selected reset-type code |

## Verification
The bench builds the block with `TICK_DIV` set to 4, so one second lasts four clocks. With that setting, full bark and bite sequences of several seconds, a pet that lands in the middle of stage two, and a zero stage-two duration each fit within a few dozen cycles. Every bark and bite is therefore compared against its exact expected clock edge. The 7-bit duration fields keep even the longest legal window within a few hundred cycles at this tick rate.

// File: rtl/bark_bite_wdt.sv
module bark_bite_wdt #(
  parameter int TICK_DIV = 32768,
  parameter int TW       = 7,
  parameter int DEF_S1   = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       bark_irq,
  output logic       rst_req,
  output logic [2:0] rst_type
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);
  localparam logic [7:0] A_STAT = 8'h10;
  localparam logic [7:0] A_S1   = 8'h54;
  localparam logic [7:0] A_S2   = 8'h55;
  localparam logic [7:0] A_TYP  = 8'h56;
  localparam logic [7:0] A_EN   = 8'h57;
  localparam logic [7:0] A_PET  = 8'h58;

  typedef enum logic [1:0] {ST_WARN, ST_GRACE, ST_DONE} stage_e;

  logic [TW-1:0] s1_dur, s2_dur, cnt;
  logic [2:0]    typ;
  logic          en, bark;
  logic [PW-1:0] pre;
  stage_e        st;

  wire wr_en   = reg_wr && reg_addr == A_EN;
  wire pet     = reg_wr && reg_addr == A_PET && reg_wdata[0];
  wire typ_ok  = reg_wdata == 8'h01 || reg_wdata == 8'h04 || reg_wdata == 8'h07;
  wire restart = pet || wr_en || !en;
  wire tick    = en && pre == PRE_LAST;

  wire [TW:0] cnt_inc = {1'b0, cnt} + 1'b1;
  wire [TW:0] limit   = (st == ST_WARN) ? {1'b0, s1_dur} : {1'b0, s2_dur};
  wire        expire  = cnt_inc >= limit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_dur  <= TW'(DEF_S1);
      s2_dur  <= '0;
      typ     <= 3'h7;
      en      <= 1'b0;
      pre     <= '0;
      cnt     <= '0;
      st      <= ST_WARN;
      bark    <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= 1'b0;
      if (reg_wr && reg_addr == A_S1) s1_dur <= reg_wdata[TW-1:0];
      if (reg_wr && reg_addr == A_S2) s2_dur <= reg_wdata[TW-1:0];
      if (reg_wr && reg_addr == A_TYP && typ_ok) typ <= reg_wdata[2:0];
      if (wr_en) en <= reg_wdata[7];
      if (restart) begin
        pre  <= '0;
        cnt  <= '0;
        st   <= ST_WARN;
        bark <= 1'b0;
      end else begin
        pre <= tick ? '0 : pre + 1'b1;
        if (tick && st != ST_DONE) begin
          if (expire) begin
            cnt <= '0;
            if (st == ST_WARN) begin
              bark <= 1'b1;
              st   <= ST_GRACE;
            end else begin
              rst_req <= 1'b1;
              st      <= ST_DONE;
            end
          end else begin
            cnt <= cnt_inc[TW-1:0];
          end
        end
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_STAT:  reg_rdata = {1'b0, bark, 6'b0};
      A_S1:    reg_rdata = 8'(s1_dur);
      A_S2:    reg_rdata = 8'(s2_dur);
      A_TYP:   reg_rdata = {5'b0, typ};
      A_EN:    reg_rdata = {en, 7'b0};
      default: reg_rdata = 8'h00;
    endcase
  end

  assign bark_irq = bark;
  assign rst_type = typ;

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  a_r3_legal_type: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (rst_type == 3'h1 || rst_type == 3'h4 || rst_type == 3'h7));
  a_r8_bite_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(en));
  a_r8_no_bark_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !bark_irq);
  a_r4_bark_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bark_irq) |-> $past(tick));
  a_r7_bark_clears_on_restart: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bark_irq) |-> $past(restart));
endmodule

// File: tb/bark_bite_wdt_bench.sv
module bark_bite_wdt_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       bark_irq, rst_req;
  logic [2:0] rst_type;

  bark_bite_wdt #(.TICK_DIV(DIV)) u_bark_bite_wdt (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bark_irq(bark_irq),
    .rst_req(rst_req), .rst_type(rst_type)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int ecount = 0;
  always @(posedge clk) ecount <= ecount + 1;

  int n_chk = 0, n_bad = 0, last_edge = 0;
  int kq[$], cq[$], tq[$];
  string rq[$];
  logic bark_q = 1'b0;
  bit done = 0;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input int kind, input int cyc, input int typ, input string req);
    kq.push_back(kind); cq.push_back(cyc); tq.push_back(typ); rq.push_back(req);
  endtask

  task automatic got(input int kind, input int typ);
    if (kq.size() == 0) begin
      n_chk++; n_bad++;
      $display("FAIL R6 unexpected event actual=%0d expected=none at %0d", kind, ecount);
    end else begin
      string r = rq.pop_front();
      check(r, kind, kq.pop_front());
      check(r, ecount, cq.pop_front());
      check(r, typ, tq.pop_front());
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (bark_irq && !bark_q) got(1, 0);
      if (rst_req) got(2, int'(rst_type));
    end
    bark_q = bark_irq;
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    last_edge = ecount;
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input int exp, input string req);
    @(negedge clk);
    reg_addr = a; #1;
    check(req, int'(reg_rdata), exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    // R1 reset state
    rd_chk(8'h54, 32, "R1");
    rd_chk(8'h55, 0, "R1");
    rd_chk(8'h56, 7, "R1");
    rd_chk(8'h57, 0, "R1");
    rd_chk(8'h10, 0, "R1");
    check("R1", int'(bark_irq), 0);
    check("R1", int'(rst_req), 0);
    rd_chk(8'h58, 0, "R2");
    rd_chk(8'h33, 0, "R2");

    // R2 / R3 programming
    wr(8'h54, 8'd3); wr(8'h55, 8'd2); wr(8'h56, 8'h01);
    rd_chk(8'h56, 1, "R3");
    wr(8'h56, 8'h03);
    rd_chk(8'h56, 1, "R3");
    rd_chk(8'h54, 3, "R2");
    rd_chk(8'h55, 2, "R2");

    // R4 R5 R9 full sequence
    wr(8'h57, 8'h80);
    push(1, last_edge + 3*DIV, 0, "R4");
    push(2, last_edge + 5*DIV, 1, "R5");
    idle(25);
    rd_chk(8'h10, 8'h40, "R4");
    rd_chk(8'h57, 8'h80, "R2");
    idle(40); // R6 hold: any event here is unexpected

    // R7 pet behaviour
    wr(8'h58, 8'h00);
    rd_chk(8'h10, 8'h40, "R7");
    wr(8'h58, 8'h01);
    rd_chk(8'h10, 0, "R7");
    push(1, last_edge + 3*DIV, 0, "R7");
    idle(14);
    wr(8'h58, 8'h01);
    rd_chk(8'h10, 0, "R7");
    push(1, last_edge + 3*DIV, 0, "R7");
    push(2, last_edge + 5*DIV, 4, "R5");
    wr(8'h56, 8'h04);
    idle(25);

    // R8 disable clears bark; R5 zero stage two
    wr(8'h57, 8'h00);
    rd_chk(8'h10, 0, "R8");
    wr(8'h54, 8'd2); wr(8'h55, 8'd0);
    wr(8'h57, 8'h80);
    push(1, last_edge + 2*DIV, 0, "R5");
    push(2, last_edge + 3*DIV, 4, "R5");
    idle(16);

    // R8 disable during stage one: no events
    wr(8'h58, 8'h01);
    idle(4);
    wr(8'h57, 8'h00);
    idle(20);
    rd_chk(8'h10, 0, "R8");
    wr(8'h57, 8'h80);
    push(1, last_edge + 2*DIV, 0, "R8");
    push(2, last_edge + 3*DIV, 4, "R8");
    idle(15);

    // R4 zero stage one counts as one tick
    wr(8'h54, 8'd0);
    wr(8'h58, 8'h01);
    push(1, last_edge + DIV, 0, "R4");
    push(2, last_edge + 2*DIV, 4, "R5");
    idle(12);

    check("R6", kq.size(), 0);
    done = 1;
    finish_run();
  end
endmodule